// File: doc/BRIEF.md
# Adjacent-Channel Correlation Averager

This block sits behind an interleaved sampling front end that delivers one full-rate sample per clock, each tagged with the index of the channel that produced it. For every neighbouring pair of channels (k, k+1) it keeps a running mean of the product of the two samples. The pair formed by the last channel and channel 0 closes the ring. A second running mean, taken over all pairs, multiplies the derivative of the later sample by the earlier sample. This gives an estimate of the slope of the input autocorrelation one sample apart. A timing-skew solver downstream uses both results. The derivative stream is computed outside and arrives alongside each sample.

Each mean is a first-order recursive average with a power-of-two time constant. The division becomes an arithmetic shift, and no past samples are stored: each pair keeps one accumulator, and the slope path keeps one. A product is formed only when a sample arrives on the cycle right after a sample from the preceding channel.

Top module: `corr_pair_avg`

## Requirements
- R1: While reset is asserted and just after it is released, every pair average and the slope average read zero and `avg_valid` is low.
- R2: A pair event happens when `in_valid` is high with tag c, and `in_valid` was high on the previous cycle with tag (c−1) mod CH. The event updates pair c−1 using the product of the current sample and the previous sample. All values are two's-complement signed.
- R3: Each accumulator A holds the mean scaled by N = 2^LOG2N. On an event it becomes A + p − (A >>> LOG2N), where p is the product. The reported average is floor(A / N), truncated to 2·DW bits. Pair k is reported at bits [k·2·DW +: 2·DW] of `pair_avg`.
- R4: Tag 0 following tag CH−1 wraps around and updates pair CH−1 (the last channel paired with channel 0).
- R5: On every pair event, the slope accumulator takes the same update as in R3, with p = `in_der` × previous sample.
- R6: When no pair event occurs, no average changes. This covers an idle cycle, a tag that does not follow the previous one, a repeated tag, and a sample after an idle gap.
- R7: A pair event changes only its own pair accumulator; every other pair average holds.
- R8: `avg_valid` rises once every pair has received at least N events, and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Sample present this cycle |
| in_ch | input | $clog2(CH) | Channel tag of the sample |
| in_smp | input | DW | Signed sample |
| in_der | input | DW | Signed derivative of the sample |
| pair_avg | output | CH·2·DW | Pair averages, pair k at slice k |
| slope_avg | output | 2·DW | Signed slope average |
| avg_valid | output | 1 | All pairs have had N updates |

## Verification
The inputs are rounds of tags in order, 0 to CH−1, using mixed-sign pseudo-random data and full-scale negative values. These show whether the product is signed and whether the shift floors negative accumulators correctly. Further tag streams skip a channel, repeat a channel, or leave an idle gap; each must leave every average untouched, which separates a correct pairing rule from one that pairs any two samples. The wrap from the last tag to tag 0 is checked on its own, and a long run shows `avg_valid` rising exactly when the slowest pair reaches N events.

// File: rtl/corr_pair_avg.sv
module corr_pair_avg #(
  parameter int CH    = 4,
  parameter int DW    = 14,
  parameter int LOG2N = 10,
  localparam int CW   = (CH > 1) ? $clog2(CH) : 1,
  localparam int PW   = 2 * DW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [CW-1:0]        in_ch,
  input  logic signed [DW-1:0] in_smp,
  input  logic signed [DW-1:0] in_der,
  output logic [CH*PW-1:0]     pair_avg,
  output logic signed [PW-1:0] slope_avg,
  output logic                 avg_valid
);
  localparam int AW = PW + LOG2N + 1;

  logic                 prev_v;
  logic [CW-1:0]        prev_ch;
  logic signed [DW-1:0] prev_smp;
  logic signed [AW-1:0] sacc;
  logic [CH-1:0]        full;

  wire [CW-1:0] pair_idx = (in_ch == '0) ? CW'(CH - 1) : in_ch - 1'b1;
  wire          fire     = in_valid && prev_v && (prev_ch == pair_idx);

  wire signed [PW-1:0] prod  = in_smp * prev_smp;
  wire signed [PW-1:0] dprod = in_der * prev_smp;

  function automatic logic signed [AW-1:0] step(input logic signed [AW-1:0] a,
                                                input logic signed [PW-1:0] p);
    logic signed [AW-1:0] pe;
    pe = {{(AW-PW){p[PW-1]}}, p};
    return a + pe - (a >>> LOG2N);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_v   <= 1'b0;
      prev_ch  <= '0;
      prev_smp <= '0;
    end else begin
      prev_v <= in_valid;
      if (in_valid) begin
        prev_ch  <= in_ch;
        prev_smp <= in_smp;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sacc <= '0;
    else if (fire) sacc <= step(sacc, dprod);
  end

  assign slope_avg = sacc[LOG2N +: PW];

  genvar g;
  for (g = 0; g < CH; g++) begin : g_pair
    logic signed [AW-1:0] acc;
    logic [LOG2N:0]       cnt;
    wire hit = fire && (pair_idx == CW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc <= '0;
        cnt <= '0;
      end else if (hit) begin
        acc <= step(acc, prod);
        if (!cnt[LOG2N]) cnt <= cnt + 1'b1;
      end
    end

    assign full[g] = cnt[LOG2N];
    assign pair_avg[g*PW +: PW] = acc[LOG2N +: PW];
  end

  assign avg_valid = &full;
endmodule

// File: rtl/corr_pair_avg_chk.sv
module corr_pair_avg_chk #(
  parameter int CH    = 4,
  parameter int DW    = 14,
  parameter int LOG2N = 10,
  localparam int CW   = (CH > 1) ? $clog2(CH) : 1,
  localparam int PW   = 2 * DW
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [CW-1:0]    in_ch,
  input logic [CH*PW-1:0] pair_avg,
  input logic [PW-1:0]    slope_avg,
  input logic             avg_valid
);
  logic          c_v;
  logic [CW-1:0] c_ch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_v  <= 1'b0;
      c_ch <= '0;
    end else begin
      c_v <= in_valid;
      if (in_valid) c_ch <= in_ch;
    end
  end

  wire [CW-1:0] c_succ = (c_ch == CW'(CH - 1)) ? '0 : c_ch + 1'b1;
  wire          c_fire = in_valid && c_v && (in_ch == c_succ);

  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pair_avg == '0 && slope_avg == '0 && !avg_valid)); // R1

  AST_NO_EVENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !c_fire |=> ($stable(pair_avg) && $stable(slope_avg))); // R6

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    avg_valid |=> avg_valid); // R8

  genvar g;
  for (g = 0; g < CH; g++) begin : g_hold
    AST_OTHER_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (c_fire && c_ch != CW'(g)) |=> $stable(pair_avg[g*PW +: PW])); // R7
  end
endmodule

bind corr_pair_avg corr_pair_avg_chk #(.CH(CH), .DW(DW), .LOG2N(LOG2N)) u_chk (.*);

// File: tb/corr_pair_avg_bench.sv
module corr_pair_avg_bench;
  localparam int CH = 4, DW = 14, LOG2N = 3, PW = 2 * DW, CW = 2;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [CW-1:0] in_ch = '0;
  logic signed [DW-1:0] in_smp = '0, in_der = '0;
  logic [CH*PW-1:0] pair_avg;
  logic signed [PW-1:0] slope_avg;
  logic avg_valid;

  corr_pair_avg #(.CH(CH), .DW(DW), .LOG2N(LOG2N)) u_corr_pair_avg (.*);

  always #10 clk = ~clk;

  typedef struct {
    logic [CH*PW-1:0] pairs;
    logic [PW-1:0]    slope;
    logic             vld;
    string            tag;
  } exp_t;

  exp_t q[$];
  int nvec = 0, nbad = 0;
  bit done = 0;

  longint macc[CH], msacc;
  int     mcnt[CH];
  bit     mpv;
  int     mpch;
  longint mpsmp;
  int     seed = 7;

  function automatic int rnd();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 8) % 8192;
  endfunction

  task automatic apply(input bit v, input int ch, input int smp, input int der, input string tag);
    exp_t e;
    bit fire;
    int pk;
    @(negedge clk);
    in_valid = v; in_ch = CW'(ch); in_smp = DW'(smp); in_der = DW'(der);
    pk = (ch == 0) ? CH - 1 : ch - 1;
    fire = v && mpv && (mpch == pk);
    if (fire) begin
      macc[pk] = macc[pk] + longint'(smp) * mpsmp - (macc[pk] >>> LOG2N);
      msacc    = msacc + longint'(der) * mpsmp - (msacc >>> LOG2N);
      mcnt[pk]++;
    end
    mpv = v;
    if (v) begin mpch = ch; mpsmp = smp; end
    for (int k = 0; k < CH; k++) e.pairs[k*PW +: PW] = PW'(macc[k] >>> LOG2N);
    e.slope = PW'(msacc >>> LOG2N);
    e.vld = 1'b1;
    for (int k = 0; k < CH; k++) if (mcnt[k] < (1 << LOG2N)) e.vld = 1'b0;
    e.tag = tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        e = q.pop_front();
        nvec++;
        if (pair_avg !== e.pairs) begin
          nbad++;
          $display("FAIL %s pair_avg act=%h exp=%h", e.tag, pair_avg, e.pairs);
        end else if (slope_avg !== e.slope) begin
          nbad++;
          $display("FAIL %s slope_avg act=%h exp=%h", e.tag, slope_avg, e.slope);
        end else if (avg_valid !== e.vld) begin
          nbad++;
          $display("FAIL %s avg_valid act=%b exp=%b", e.tag, avg_valid, e.vld);
        end
      end
    end
  end

  task automatic round(input string tag);
    for (int c = 0; c < CH; c++) apply(1, c, rnd(), rnd(), tag);
  endtask

  initial begin : main
    for (int k = 0; k < CH; k++) begin macc[k] = 0; mcnt[k] = 0; end
    msacc = 0; mpv = 0; mpch = 0; mpsmp = 0;
    repeat (3) @(posedge clk);
    #5;
    nvec++;
    if (pair_avg !== '0 || slope_avg !== '0 || avg_valid !== 1'b0) begin
      nbad++;
      $display("FAIL R1 reset act=%h/%h/%b exp=0/0/0", pair_avg, slope_avg, avg_valid);
    end
    @(negedge clk);
    rst_n = 1'b1;
    apply(0, 0, 0, 0, "R1");
    // R2 R3: in-order rounds, mixed signs
    apply(1, 0, 100, 5, "R2");
    apply(1, 1, -300, 7, "R2");
    apply(1, 2, 250, -9, "R3");
    apply(1, 3, -8192, 11, "R3");
    // R4: wrap from last channel to channel 0
    apply(1, 0, -8192, -8192, "R4");
    apply(1, 1, 8191, 3, "R5");
    // R6: skipped, repeated, gap
    apply(1, 3, 500, 500, "R6");
    apply(1, 3, 600, 600, "R6");
    apply(0, 0, 700, 700, "R6");
    apply(1, 1, 800, 800, "R6");
    apply(1, 1, 900, 900, "R6");
    // R7: single pair update, others hold
    apply(1, 2, -4000, 1234, "R7");
    apply(0, 0, 0, 0, "R7");
    // R5 R3: random rounds, valid still low while counts short
    for (int i = 0; i < 5; i++) round("R5");
    // R8: run until every pair reaches N events and beyond
    for (int i = 0; i < 6; i++) round("R8");
    apply(0, 0, 0, 0, "R8");
    apply(1, 2, 10, 10, "R8");
    for (int i = 0; i < 3; i++) round("R8");
    apply(0, 0, 0, 0, "R8");
    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin : watchdog
    #(20 * 100000);
    if (!done) begin
      done = 1;
      nbad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule